// File: doc/BRIEF.md
# Software-Sequenced SPI Flash Cycle Engine

This block is an SPI flash master controlled through registers. It carries out exactly one flash cycle for each "go" that software writes. Software first sets up an eight-entry opcode menu and a packed word that gives each menu entry its type. It also loads a prefix opcode, a 24-bit flash address and up to 64 data bytes. It then writes a control word that names a menu entry and sets the cycle options.

On go, the engine can optionally send the prefix opcode on its own first, in a separate chip-select frame. It then opens the main frame and sends, in order: the chosen opcode, three address bytes if the entry's type calls for them, and finally the data bytes. Data bytes go out from the buffer on a write and come back into the buffer on a read. Three status flags report the cycle: busy, done and error. Done and error stay set until software clears them.

A lock bit, once set, freezes the menu, the type word and the prefix register until the next reset. The SPI clock is derived from the system clock by one of two half-period dividers, and a speed bit in the control word picks which one.

Top module: `spi_sseq_engine`

## Requirements
- R1: After reset, every register reads zero (the data buffer included), CS_n is high and SCLK is low.
- R2: The control word has these fields: go in bit 0, atomic in bit 1, speed in bit 2, menu index in bits 6:4, byte count minus one in bits 13:8, and data-present in bit 14. The opcode sent is the menu byte at that index. Menu entry k sits in word 5 (k<4) or word 6 (k≥4), at bits 8*(k mod 4). The entry's type is read from bits 2k+1:2k of the type word (word 4). Type bit 1 means an address follows the opcode. Type bit 0 means data is written to the flash rather than read from it.
- R3: For a type that carries an address, three bytes follow the opcode, taken from address register bits 23:16, then 15:8, then 7:0. Address register bits 31:24 are discarded and read back as zero.
- R4: On a write with data-present set, count+1 buffer bytes follow the header. Byte j is stored in data word 16+j/4 at bits 8*(j mod 4).
- R5: On a read with data-present set, count+1 bytes are sampled from MISO after the header and stored into the buffer in the same layout as R4.
- R6: When data-present is clear, the frame carries only the opcode, plus the address when the type has one.
- R7: The status word holds busy in bit 0, done in bit 1, error in bit 2 and lock in bit 3. Busy is set from the cycle after go until the frame ends. Done is then set. Writing 1 to bit 1 clears done, and writing 1 to bit 2 clears error.
- R8: A go written while busy sets error, starts no new frame, and leaves the control fields unchanged.
- R9: With atomic set, the prefix register (word 3) is sent alone in its own CS_n frame. That frame is followed by a CS_n-high gap of at least one SCLK period, and then by the main frame.
- R10: Writing 1 to bit 0 of word 7 sets lock. While locked, writes to the menu, type and prefix registers have no effect until reset.
- R11: The SCLK period is 2*HALF_FAST system clocks when speed is set, and 2*HALF_SLOW system clocks when speed is clear.
- R12: SPI mode 0 is used. SCLK is low whenever CS_n is high. MOSI sends the MSB first and changes only after falling edges. MISO is sampled on rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Word address; bit 4 selects the data buffer |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| spi_sclk_o | output | 1 | SPI clock |
| spi_cs_n_o | output | 1 | SPI chip select, active low |
| spi_mosi_o | output | 1 | Serial data to the flash |
| spi_miso_i | input | 1 | Serial data from the flash |

## Verification
The assertions assume that reset is held for several clocks. They also assume that register writes are single-cycle strobes with a settled address and data, and that MISO changes only while SCLK is low. The bench drives register writes on falling clock edges and holds the strobe for one cycle. Its flash model updates MISO only on the falling edge of SCLK, or when CS_n falls. Both choices keep the stimulus within these assumptions.

// File: rtl/spi_sseq_pkg.sv
`timescale 1ns/1ps
package spi_sseq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_GAP, ST_OPC, ST_ADR, ST_DAT, ST_END
  } seq_st_e;

  localparam logic [2:0] A_CTRL  = 3'd0;
  localparam logic [2:0] A_STAT  = 3'd1;
  localparam logic [2:0] A_ADDR  = 3'd2;
  localparam logic [2:0] A_PREF  = 3'd3;
  localparam logic [2:0] A_TYPE  = 3'd4;
  localparam logic [2:0] A_MENU0 = 3'd5;
  localparam logic [2:0] A_MENU1 = 3'd6;
  localparam logic [2:0] A_LOCK  = 3'd7;

  localparam int CB_GO   = 0;
  localparam int CB_ATOM = 1;
  localparam int CB_SPD  = 2;
  localparam int CB_IDX  = 4;
  localparam int CB_CNT  = 8;
  localparam int CB_DP   = 14;
endpackage

// File: rtl/spi_sseq_shifter.sv
`timescale 1ns/1ps
module spi_sseq_shifter #(
  parameter int HW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [HW-1:0] half_i,
  input  logic [7:0]    tx_i,
  input  logic          miso_i,
  output logic          sclk_o,
  output logic          mosi_o,
  output logic [7:0]    rx_o,
  output logic          done_o
);
  logic          busy_q;
  logic [HW-1:0] cnt_q;
  logic [2:0]    bit_q;
  logic [7:0]    sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0; cnt_q <= '0; bit_q <= '0; sh_q <= '0;
      rx_o <= '0; sclk_o <= 1'b0; done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i && !busy_q) begin
        busy_q <= 1'b1; sh_q <= tx_i; sclk_o <= 1'b0;
        cnt_q <= '0; bit_q <= '0;
      end else if (busy_q) begin
        if (cnt_q == half_i - HW'(1)) begin
          cnt_q <= '0;
          if (!sclk_o) begin
            sclk_o <= 1'b1;
            rx_o   <= {rx_o[6:0], miso_i};
          end else begin
            sclk_o <= 1'b0;
            if (bit_q == 3'd7) begin
              busy_q <= 1'b0; done_o <= 1'b1;
            end else begin
              bit_q <= bit_q + 3'd1;
              sh_q  <= {sh_q[6:0], 1'b0};
            end
          end
        end else begin
          cnt_q <= cnt_q + HW'(1);
        end
      end
    end
  end

  assign mosi_o = sh_q[7];
endmodule

// File: rtl/spi_sseq_seq.sv
`timescale 1ns/1ps
module spi_sseq_seq import spi_sseq_pkg::*; #(
  parameter int CNTW = 6,
  parameter int GW   = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            go_i,
  input  logic            atomic_i,
  input  logic [7:0]      pre_i,
  input  logic [7:0]      opc_i,
  input  logic [1:0]      type_i,
  input  logic [23:0]     addr_i,
  input  logic            dp_i,
  input  logic [CNTW-1:0] last_i,
  input  logic [GW-1:0]   gap_i,
  input  logic            sh_done_i,
  input  logic [7:0]      sh_rx_i,
  input  logic [7:0]      buf_rbyte_i,
  output logic            kick_o,
  output logic [7:0]      tx_o,
  output logic            cs_n_o,
  output logic            busy_o,
  output logic            done_o,
  output logic [CNTW-1:0] buf_ridx_o,
  output logic            buf_we_o,
  output logic [CNTW-1:0] buf_widx_o,
  output logic [7:0]      buf_wbyte_o
);
  seq_st_e         st_q;
  logic [GW-1:0]   gcnt_q;
  logic [1:0]      an_q;
  logic [CNTW-1:0] idx_q;
  logic [7:0]      opc_q;
  logic [1:0]      typ_q;
  logic [23:0]     adr_q;

  always_comb begin
    busy_o      = (st_q != ST_IDLE);
    done_o      = (st_q == ST_END);
    buf_ridx_o  = (st_q == ST_DAT) ? idx_q + CNTW'(1) : '0;
    buf_we_o    = (st_q == ST_DAT) && sh_done_i && !typ_q[0];
    buf_widx_o  = idx_q;
    buf_wbyte_o = sh_rx_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; gcnt_q <= '0; an_q <= '0; idx_q <= '0;
      opc_q <= '0; typ_q <= '0; adr_q <= '0;
      kick_o <= 1'b0; tx_o <= '0; cs_n_o <= 1'b1;
    end else begin
      kick_o <= 1'b0;
      case (st_q)
        ST_IDLE: if (go_i) begin
          opc_q <= opc_i; typ_q <= type_i; adr_q <= addr_i;
          cs_n_o <= 1'b0; kick_o <= 1'b1;
          if (atomic_i) begin st_q <= ST_PRE; tx_o <= pre_i; end
          else          begin st_q <= ST_OPC; tx_o <= opc_i; end
        end
        ST_PRE: if (sh_done_i) begin
          cs_n_o <= 1'b1; gcnt_q <= '0; st_q <= ST_GAP;
        end
        ST_GAP: begin
          if (gcnt_q == gap_i - GW'(1)) begin
            cs_n_o <= 1'b0; kick_o <= 1'b1; tx_o <= opc_q; st_q <= ST_OPC;
          end else gcnt_q <= gcnt_q + GW'(1);
        end
        ST_OPC: if (sh_done_i) begin
          if (typ_q[1]) begin
            st_q <= ST_ADR; an_q <= '0; tx_o <= adr_q[23:16]; kick_o <= 1'b1;
          end else if (dp_i) begin
            st_q <= ST_DAT; idx_q <= '0; tx_o <= buf_rbyte_i; kick_o <= 1'b1;
          end else begin
            st_q <= ST_END; cs_n_o <= 1'b1;
          end
        end
        ST_ADR: if (sh_done_i) begin
          if (an_q == 2'd2) begin
            if (dp_i) begin
              st_q <= ST_DAT; idx_q <= '0; tx_o <= buf_rbyte_i; kick_o <= 1'b1;
            end else begin
              st_q <= ST_END; cs_n_o <= 1'b1;
            end
          end else begin
            an_q <= an_q + 2'd1; kick_o <= 1'b1;
            tx_o <= (an_q == 2'd0) ? adr_q[15:8] : adr_q[7:0];
          end
        end
        ST_DAT: if (sh_done_i) begin
          if (idx_q == last_i) begin
            st_q <= ST_END; cs_n_o <= 1'b1;
          end else begin
            idx_q <= idx_q + CNTW'(1); tx_o <= buf_rbyte_i; kick_o <= 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_sseq_engine.sv
`timescale 1ns/1ps
module spi_sseq_engine import spi_sseq_pkg::*; #(
  parameter int DATA_BYTES = 64,
  parameter int HALF_SLOW  = 3,
  parameter int HALF_FAST  = 2
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           reg_wr_i,
  input  logic [$clog2(DATA_BYTES/4):0]  reg_addr_i,
  input  logic [31:0]                    reg_wdata_i,
  output logic [31:0]                    reg_rdata_o,
  output logic                           spi_sclk_o,
  output logic                           spi_cs_n_o,
  output logic                           spi_mosi_o,
  input  logic                           spi_miso_i
);
  localparam int CNTW = $clog2(DATA_BYTES);
  localparam int WAW  = $clog2(DATA_BYTES / 4);
  localparam int HW   = $clog2(HALF_SLOW + 1);
  localparam int GW   = HW + 1;

  logic [7:0][7:0] menu_q;
  logic [15:0]     types_q;
  logic [7:0]      pref_q;
  logic            lock_q;
  logic            c_atomic, c_speed, c_dp;
  logic [2:0]      c_idx;
  logic [CNTW-1:0] c_cnt;
  logic [23:0]     addr_q;
  logic            st_done_q, st_err_q, start_q;
  logic [7:0]      dbuf [DATA_BYTES];

  logic            is_data, go_wr, stat_wr, busy, seq_busy, seq_done;
  logic [2:0]      rsel;
  logic [WAW-1:0]  widx;
  logic [HW-1:0]   half_sel;
  logic            kick, sh_done;
  logic [7:0]      tx_byte, rx_byte, buf_rbyte, buf_wbyte;
  logic [CNTW-1:0] buf_ridx, buf_widx;
  logic            buf_we;

  assign is_data  = reg_addr_i[WAW];
  assign rsel     = reg_addr_i[2:0];
  assign widx     = reg_addr_i[WAW-1:0];
  assign go_wr    = reg_wr_i && !is_data && (rsel == A_CTRL) && reg_wdata_i[CB_GO];
  assign stat_wr  = reg_wr_i && !is_data && (rsel == A_STAT);
  assign busy     = seq_busy || start_q;
  assign half_sel = c_speed ? HALF_FAST[HW-1:0] : HALF_SLOW[HW-1:0];
  assign buf_rbyte = dbuf[buf_ridx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      menu_q <= '0; types_q <= '0; pref_q <= '0; lock_q <= 1'b0;
      c_atomic <= 1'b0; c_speed <= 1'b0; c_dp <= 1'b0; c_idx <= '0; c_cnt <= '0;
      addr_q <= '0; st_done_q <= 1'b0; st_err_q <= 1'b0; start_q <= 1'b0;
    end else begin
      start_q <= go_wr && !busy;
      if (reg_wr_i && !is_data) begin
        case (rsel)
          A_CTRL: if (!busy) begin
            c_atomic <= reg_wdata_i[CB_ATOM];
            c_speed  <= reg_wdata_i[CB_SPD];
            c_idx    <= reg_wdata_i[CB_IDX +: 3];
            c_cnt    <= reg_wdata_i[CB_CNT +: CNTW];
            c_dp     <= reg_wdata_i[CB_DP];
          end
          A_ADDR:  addr_q <= reg_wdata_i[23:0];
          A_PREF:  if (!lock_q) pref_q <= reg_wdata_i[7:0];
          A_TYPE:  if (!lock_q) types_q <= reg_wdata_i[15:0];
          A_MENU0: if (!lock_q) menu_q[3:0] <= reg_wdata_i;
          A_MENU1: if (!lock_q) menu_q[7:4] <= reg_wdata_i;
          A_LOCK:  if (reg_wdata_i[0]) lock_q <= 1'b1;
          default: ;
        endcase
      end
      if (seq_done) st_done_q <= 1'b1;
      else if (stat_wr && reg_wdata_i[1]) st_done_q <= 1'b0;
      if (go_wr && busy) st_err_q <= 1'b1;
      else if (stat_wr && reg_wdata_i[2]) st_err_q <= 1'b0;
    end
  end

  // engine writes win over a same-cycle software write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DATA_BYTES; i++) dbuf[i] <= '0;
    end else begin
      if (reg_wr_i && is_data)
        for (int j = 0; j < 4; j++) dbuf[{widx, 2'(j)}] <= reg_wdata_i[8*j +: 8];
      if (buf_we) dbuf[buf_widx] <= buf_wbyte;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (is_data) begin
      for (int j = 0; j < 4; j++) reg_rdata_o[8*j +: 8] = dbuf[{widx, 2'(j)}];
    end else begin
      case (rsel)
        A_CTRL: begin
          reg_rdata_o[CB_ATOM]       = c_atomic;
          reg_rdata_o[CB_SPD]        = c_speed;
          reg_rdata_o[CB_IDX +: 3]   = c_idx;
          reg_rdata_o[CB_CNT +: CNTW] = c_cnt;
          reg_rdata_o[CB_DP]         = c_dp;
        end
        A_STAT:  reg_rdata_o[3:0]  = {lock_q, st_err_q, st_done_q, busy};
        A_ADDR:  reg_rdata_o[23:0] = addr_q;
        A_PREF:  reg_rdata_o[7:0]  = pref_q;
        A_TYPE:  reg_rdata_o[15:0] = types_q;
        A_MENU0: reg_rdata_o       = menu_q[3:0];
        A_MENU1: reg_rdata_o       = menu_q[7:4];
        default: reg_rdata_o[0]    = lock_q;
      endcase
    end
  end

  spi_sseq_seq #(.CNTW(CNTW), .GW(GW)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .go_i(start_q), .atomic_i(c_atomic),
    .pre_i(pref_q), .opc_i(menu_q[c_idx]), .type_i(types_q[{c_idx, 1'b0} +: 2]),
    .addr_i(addr_q), .dp_i(c_dp), .last_i(c_cnt), .gap_i({half_sel, 1'b0}),
    .sh_done_i(sh_done), .sh_rx_i(rx_byte), .buf_rbyte_i(buf_rbyte),
    .kick_o(kick), .tx_o(tx_byte), .cs_n_o(spi_cs_n_o), .busy_o(seq_busy),
    .done_o(seq_done), .buf_ridx_o(buf_ridx), .buf_we_o(buf_we),
    .buf_widx_o(buf_widx), .buf_wbyte_o(buf_wbyte)
  );

  spi_sseq_shifter #(.HW(HW)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(kick), .half_i(half_sel),
    .tx_i(tx_byte), .miso_i(spi_miso_i), .sclk_o(spi_sclk_o),
    .mosi_o(spi_mosi_o), .rx_o(rx_byte), .done_o(sh_done)
  );
endmodule

// File: rtl/spi_sseq_chk.sv
`timescale 1ns/1ps
module spi_sseq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cs_n,
  input logic        sclk,
  input logic        busy,
  input logic        done_f,
  input logic        err_f,
  input logic        lock,
  input logic        go_wr,
  input logic [63:0] menu,
  input logic [15:0] types,
  input logic [7:0]  pref
);
  p_sclk_idle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n |-> !sclk);
  p_cs_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> cs_n);
  p_done_after_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_f) |-> $past(busy));
  p_go_busy_err_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_wr && busy) |=> err_f);
  p_lock_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock |=> lock);
  p_lock_freeze_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock |=> ($stable(menu) && $stable(types) && $stable(pref)));
endmodule

bind spi_sseq_engine spi_sseq_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_n(spi_cs_n_o), .sclk(spi_sclk_o),
  .busy(busy), .done_f(st_done_q), .err_f(st_err_q), .lock(lock_q),
  .go_wr(go_wr), .menu(menu_q), .types(types_q), .pref(pref_q)
);

// File: tb/spi_sseq_engine_test.sv
`timescale 1ns/1ps
module spi_sseq_engine_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic sclk, cs_n, mosi, miso = 1'b0;

  always #5 clk = ~clk;

  spi_sseq_engine uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .spi_sclk_o(sclk),
    .spi_cs_n_o(cs_n), .spi_mosi_o(mosi), .spi_miso_i(miso)
  );

  int nchk = 0, nerr = 0;
  bit finished = 0;

  // flash model: logs MOSI bytes per frame, drives MISO pattern
  logic [7:0] log_b [0:255];
  int log_f [0:255];
  int nlog = 0, frame_no = 0, bitc = 0;
  logic [7:0] sh = '0;
  longint t_rise = 0, last_sck = 0, period = 0, gap = 0;

  function automatic logic [7:0] rbyte(int n);
    return 8'h5A ^ 8'(n * 29);
  endfunction

  function automatic logic rbit(int b);
    logic [7:0] v;
    v = rbyte(b / 8);
    return v[7 - (b % 8)];
  endfunction

  always @(negedge cs_n) begin
    frame_no = frame_no + 1; bitc = 0; gap = $time - t_rise; miso = rbit(0);
  end
  always @(posedge cs_n) t_rise = $time;
  always @(posedge sclk) if (!cs_n) begin
    if (bitc % 8 != 0) period = $time - last_sck;
    last_sck = $time;
    sh = {sh[6:0], mosi};
    bitc = bitc + 1;
    if (bitc % 8 == 0 && nlog < 256) begin
      log_b[nlog] = sh; log_f[nlog] = frame_no; nlog = nlog + 1;
    end
  end
  always @(negedge sclk) if (!cs_n) miso = rbit(bitc);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 5000; i++) begin
      rd(5'd1, s);
      if (!s[0]) break;
    end
  endtask

  function automatic logic [31:0] ctl(bit atom, bit spd, int idx, int cnt, bit dp);
    return 32'(1) | (32'(atom) << 1) | (32'(spd) << 2) | (32'(idx) << 4) |
           (32'(cnt) << 8) | (32'(dp) << 14);
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    rd(5'd1, d); chk("R1 status", d, 32'h0);
    rd(5'd0, d); chk("R1 ctrl", d, 32'h0);
    rd(5'd16, d); chk("R1 buffer", d, 32'h0);
    chk("R1 cs_n", {31'h0, cs_n}, 32'h1);
    chk("R1 sclk", {31'h0, sclk}, 32'h0);
  endtask

  task automatic t_config();
    logic [31:0] d;
    wr(5'd5, 32'h04050203);
    wr(5'd6, 32'h009F0B00);
    wr(5'd4, 32'h0000084E);
    wr(5'd3, 32'h00000006);
    rd(5'd4, d); chk("R2 types readback", d, 32'h84E);
  endtask

  task automatic t_read_addr();
    logic [31:0] d; int m;
    wr(5'd2, 32'hAB123456);
    rd(5'd2, d); chk("R3 addr upper bits dropped", d, 32'h00123456);
    m = nlog;
    wr(5'd0, ctl(0, 0, 0, 3, 1));
    wait_idle();
    chk("R5 byte count", nlog - m, 8);
    chk("R2 opcode idx0", log_b[m], 8'h03);
    chk("R3 addr msb", log_b[m+1], 8'h12);
    chk("R3 addr mid", log_b[m+2], 8'h34);
    chk("R3 addr lsb", log_b[m+3], 8'h56);
    rd(5'd16, d);
    chk("R5 read data", d, {rbyte(7), rbyte(6), rbyte(5), rbyte(4)});
    chk("R11 slow period", 32'(period), 32'd60);
    rd(5'd1, d); chk("R7 done set", d, 32'h2);
    chk("R12 sclk idle low", {31'h0, sclk}, 32'h0);
    wr(5'd1, 32'h2);
    rd(5'd1, d); chk("R7 done cleared", d, 32'h0);
  endtask

  task automatic t_write_fast();
    logic [31:0] d; int m;
    wr(5'd16, 32'h44332211);
    wr(5'd17, 32'h88776655);
    wr(5'd2, 32'h00ABCDEF);
    m = nlog;
    wr(5'd0, ctl(0, 1, 1, 5, 1));
    wait_idle();
    chk("R4 byte count", nlog - m, 10);
    chk("R2 opcode idx1", log_b[m], 8'h02);
    chk("R3 addr msb", log_b[m+1], 8'hAB);
    chk("R3 addr lsb", log_b[m+3], 8'hEF);
    for (int k = 0; k < 6; k++)
      chk("R4 write data", log_b[m+4+k], 8'(8'h11 * (k + 1)));
    chk("R11 fast period", 32'(period), 32'd40);
    wr(5'd1, 32'h6);
  endtask

  task automatic t_busy_go();
    logic [31:0] d; int f0;
    f0 = frame_no;
    wr(5'd0, ctl(0, 0, 1, 7, 1));
    rd(5'd1, d); chk("R7 busy during cycle", d, 32'h1);
    wr(5'd0, ctl(1, 1, 2, 0, 0));
    rd(5'd1, d); chk("R8 error on busy go", d, 32'h5);
    wait_idle();
    chk("R8 one frame only", frame_no - f0, 1);
    rd(5'd0, d); chk("R8 ctrl unchanged", d, ctl(0, 0, 1, 7, 1) & ~32'h1);
    rd(5'd1, d); chk("R7 done+error", d, 32'h6);
    wr(5'd1, 32'h2);
    rd(5'd1, d); chk("R7 only done cleared", d, 32'h4);
    wr(5'd1, 32'h4);
    rd(5'd1, d); chk("R7 error cleared", d, 32'h0);
  endtask

  task automatic t_nodata();
    int m;
    m = nlog;
    wr(5'd0, ctl(0, 0, 0, 9, 0));
    wait_idle();
    chk("R6 addressed header only", nlog - m, 4);
    m = nlog;
    wr(5'd0, ctl(0, 0, 2, 9, 0));
    wait_idle();
    chk("R6 opcode only", nlog - m, 1);
    chk("R2 opcode idx2", log_b[m], 8'h05);
    m = nlog;
    wr(5'd0, ctl(0, 0, 5, 0, 0));
    wait_idle();
    chk("R2 idx5 type addressed", nlog - m, 4);
    chk("R2 opcode idx5", log_b[m], 8'h0B);
    m = nlog;
    wr(5'd0, ctl(0, 0, 6, 0, 0));
    wait_idle();
    chk("R2 idx6 type no address", nlog - m, 1);
    chk("R2 opcode idx6", log_b[m], 8'h9F);
    wr(5'd1, 32'h6);
  endtask

  task automatic t_atomic();
    int m;
    m = nlog;
    wr(5'd0, ctl(1, 0, 1, 0, 1));
    wait_idle();
    chk("R9 total bytes", nlog - m, 6);
    chk("R9 prefix byte", log_b[m], 8'h06);
    chk("R9 main opcode", log_b[m+1], 8'h02);
    chk("R9 separate frames", log_f[m+1] - log_f[m], 1);
    chk("R9 gap >= period", 32'(gap >= period), 32'h1);
    wr(5'd1, 32'h6);
  endtask

  task automatic t_lock();
    logic [31:0] d; int m;
    wr(5'd7, 32'h1);
    rd(5'd1, d); chk("R10 lock status", d, 32'h8);
    wr(5'd5, 32'hFFFFFFFF);
    wr(5'd4, 32'hFFFF);
    wr(5'd3, 32'hEE);
    rd(5'd5, d); chk("R10 menu frozen", d, 32'h04050203);
    rd(5'd4, d); chk("R10 types frozen", d, 32'h84E);
    rd(5'd3, d); chk("R10 prefix frozen", d, 32'h06);
    m = nlog;
    wr(5'd0, ctl(0, 0, 0, 0, 0));
    wait_idle();
    chk("R10 locked opcode used", log_b[m], 8'h03);
    chk("R12 cs_n idle high", {31'h0, cs_n}, 32'h1);
  endtask

  initial begin
    #1_500_000;
    if (!finished) begin
      nerr++; nchk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_config();
    t_read_addr();
    t_write_fast();
    t_busy_go();
    t_nodata();
    t_atomic();
    t_lock();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule